// File: doc/BRIEF.md
# Maskable Dual Alarm Comparator

This block watches a live BCD time value and raises an event when it agrees with one of two programmed alarm settings. Each alarm carries six match values (seconds, minutes, hours, date, month and weekday) and a six-bit mask that chooses which of them take part. Only the chosen fields are compared. Enabling only seconds with a value of 00 therefore fires once a minute, and enabling only the weekday fires on every such day. The comparison happens only in a cycle where the one-cycle second tick is high, so an alarm can set at most once per tick.

An event sets a per-alarm status flag that software polls and clears with a one-cycle strobe. Each alarm also has an interrupt enable and a mode bit. In level mode the alarm pulls the shared active-low interrupt line for as long as the condition stays latched. In pulse mode each event pulls the line for a fixed number of clock cycles and then releases it, which gives a periodic interrupt when the mask matches repeatedly. The interrupt pin is open drain. It is modelled as 0 for "drive low" and 1 for "released".

Each alarm has a small controller with three states. ST_IDLE means no interrupt request. ST_LEVEL holds the request until a clear. ST_PULSE counts down the pulse. The transitions are:
- fire_level: from any state to ST_LEVEL on a match with the mode bit at 0.
- fire_pulse: from any state to ST_PULSE on a match with the mode bit at 1, reloading the counter.
- level_clear: ST_LEVEL to ST_IDLE on a clear strobe with no match.
- pulse_done: ST_PULSE to ST_IDLE when the counter reaches zero.
- pulse_step: ST_PULSE stays in ST_PULSE and decrements the counter.

Top module: `dual_alarm_cmp`

## Requirements
- R1: Time and alarm words are 34 bits wide, laid out as follows:
  - seconds in [6:0]
  - minutes in [13:7]
  - hours in [19:14]
  - date in [25:20]
  - month in [30:26]
  - weekday in [33:31]

  When `sec_tick` is high and every enabled field of an alarm equals the same field of `now_time`, that alarm's flag reads 1 after the next rising clock edge.
- R2: The mask bits are ordered as bit 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday. A field whose mask bit is 0 has no effect on the match.
- R3: An alarm whose six mask bits are all 0 never sets its flag and never requests an interrupt.
- R4: When `sec_tick` is low, no flag sets and no new interrupt starts, even if the time matches.
- R5: A flag stays at 1 until a clear strobe for that alarm. It is 0 after the edge that samples the strobe. A match in the same cycle as the strobe wins, and the flag stays 1.
- R6: In level mode (mode bit 0) with the interrupt enabled, `irq_n` is 0 from the edge after the match until the edge that samples a clear strobe without a match.
- R7: In pulse mode (mode bit 1) with the interrupt enabled, `irq_n` is 0 for exactly PULSE_CYCLES clock cycles after each match. A new match restarts the count. The flag still sets, and a clear does not cut the pulse short.
- R8: `irq_n` is 0 exactly when at least one alarm has its interrupt enable at 1 and its controller out of ST_IDLE. An alarm with the enable at 0 can still set its flag.
- R9: The two alarms evaluate, set and clear independently of each other.
- R10: While `rst_n` is low and after its release, both flags are 0 and `irq_n` is 1 until a match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| now_time | input | 34 | Live BCD time, layout per R1 |
| alm_time | input | 68 | Alarm match values; alarm a in [a*34 +: 34] |
| alm_field_en | input | 12 | Field masks; alarm a in [a*6 +: 6], order per R2 |
| alm_pulse_mode | input | 2 | Per alarm: 1 selects pulse mode, 0 level mode |
| alm_irq_en | input | 2 | Per alarm interrupt enable |
| alm_clear | input | 2 | Per alarm one-cycle flag clear strobe |
| alm_flag | output | 2 | Per alarm status flag |
| irq_n | output | 1 | Interrupt, 0 drives the line low, 1 releases it |

## Verification
- **Flags:** a flag is due one edge after the cycle in which `sec_tick`, the mask and the time line up.
- **Level interrupt:** `irq_n` falls at the same edge as the flag. It is combinational from the controller state and the live enables, so a change of enable shows without delay.
- **Pulse interrupt:** a pulse stays low for PULSE_CYCLES edges.
- **Sampling:** the bench drives inputs just after a falling edge and advances a reference model at the rising edge using the inputs it applied. It compares every flag and `irq_n` at the following falling edge, so each result is checked in the cycle it becomes due. Directed sequences also count low cycles of the pulse window explicitly.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int TIME_W     = 34;

    // Field order: seconds, minutes, hours, date, month, weekday.
    localparam int FLD_LO [NUM_FIELDS] = '{0, 7, 14, 20, 26, 31};
    localparam int FLD_W  [NUM_FIELDS] = '{7, 7, 6, 6, 5, 3};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEVEL = 2'd1,
        ST_PULSE = 2'd2
    } slot_state_e;

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  logic [TIME_W-1:0]     now_time,
    input  logic [TIME_W-1:0]     alm_time,
    input  logic [NUM_FIELDS-1:0] field_en,
    output logic                  hit
);

    logic [NUM_FIELDS-1:0] field_eq;

    // One equality comparator per field, sized from the package layout.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign field_eq[g] = (now_time[FLD_LO[g] +: FLD_W[g]] ==
                              alm_time[FLD_LO[g] +: FLD_W[g]]);
    end

    // A masked-out field passes; an empty mask never hits.
    always_comb begin
        hit = (|field_en) && (&(field_eq | ~field_en));
    end

endmodule

// File: rtl/alarm_slot.sv
module alarm_slot
    import alarm_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic hit,
    input  logic pulse_mode,
    input  logic irq_en,
    input  logic clear,
    output logic flag,
    output logic irq_req
);

    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;

    assign fire = sec_tick & hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    state_d = pulse_mode ? ST_PULSE : ST_LEVEL;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_LEVEL: begin
                if (fire) begin
                    state_d = pulse_mode ? ST_PULSE : ST_LEVEL;
                    cnt_d   = CNT_LOAD;
                end else if (clear) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PULSE: begin
                if (fire) begin
                    state_d = pulse_mode ? ST_PULSE : ST_LEVEL;
                    cnt_d   = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Status flag: a match has priority over the clear strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (fire) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        irq_req = irq_en && (state_q != ST_IDLE);
    end

    a_r4_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !$rose(flag))
        else $error("flag rose without a second tick");

    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear) |=> flag)
        else $error("flag dropped without a clear");

    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !sec_tick) |=> !flag)
        else $error("clear strobe did not drop the flag");

    a_r6_level_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEVEL) |-> flag)
        else $error("level state without a set flag");

    a_r6_level_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEVEL && !clear) |=> (state_q != ST_IDLE))
        else $error("level request dropped without a clear");

endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp
    import alarm_pkg::*;
#(
    parameter int NUM_ALARMS   = 2,
    parameter int PULSE_CYCLES = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sec_tick,
    input  logic [TIME_W-1:0]                now_time,
    input  logic [NUM_ALARMS*TIME_W-1:0]     alm_time,
    input  logic [NUM_ALARMS*NUM_FIELDS-1:0] alm_field_en,
    input  logic [NUM_ALARMS-1:0]            alm_pulse_mode,
    input  logic [NUM_ALARMS-1:0]            alm_irq_en,
    input  logic [NUM_ALARMS-1:0]            alm_clear,
    output logic [NUM_ALARMS-1:0]            alm_flag,
    output logic                             irq_n
);

    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] irq_req;

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_match u_match (
            .now_time (now_time),
            .alm_time (alm_time[a*TIME_W +: TIME_W]),
            .field_en (alm_field_en[a*NUM_FIELDS +: NUM_FIELDS]),
            .hit      (hit[a])
        );

        alarm_slot #(
            .PULSE_CYCLES (PULSE_CYCLES)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sec_tick   (sec_tick),
            .hit        (hit[a]),
            .pulse_mode (alm_pulse_mode[a]),
            .irq_en     (alm_irq_en[a]),
            .clear      (alm_clear[a]),
            .flag       (alm_flag[a]),
            .irq_req    (irq_req[a])
        );

        a_r3_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_field_en[a*NUM_FIELDS +: NUM_FIELDS] == '0 && !alm_flag[a])
            |=> !alm_flag[a])
            else $error("alarm with empty mask set its flag");

        a_r9_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (alm_flag[a] && !alm_clear[a]) |=> alm_flag[a])
            else $error("flag lost without its own clear");
    end

    // Open-drain line: any enabled request drives it low
    always_comb begin
        irq_n = ~(|irq_req);
    end

    a_r10_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && alm_irq_en == '0) |-> irq_n)
        else $error("interrupt driven right after reset");

endmodule

// File: tb/tb_dual_alarm_cmp.sv
module tb_dual_alarm_cmp;
    import alarm_pkg::*;

    localparam int N = 2;
    localparam int P = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                     rst_n;
    logic                     tick;
    logic [TIME_W-1:0]        now;
    logic [N*TIME_W-1:0]      at;
    logic [N*NUM_FIELDS-1:0]  fe;
    logic [N-1:0]             pm, ie, clr;
    logic [N-1:0]             flag;
    logic                     irq_n;

    int    vectors = 0;
    int    errs    = 0;
    bit    done    = 0;
    string tag     = "R10";

    int m_st  [N];
    int m_cnt [N];
    bit m_flag[N];

    dual_alarm_cmp #(.NUM_ALARMS(N), .PULSE_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .now_time(now),
        .alm_time(at), .alm_field_en(fe), .alm_pulse_mode(pm),
        .alm_irq_en(ie), .alm_clear(clr), .alm_flag(flag), .irq_n(irq_n)
    );

    function automatic logic [TIME_W-1:0] mk(int s, int mi, int h, int d, int mo, int w);
        logic [TIME_W-1:0] t;
        t = {3'(w), 5'(mo), 6'(d), 6'(h), 7'(mi), 7'(s)};
        return t;
    endfunction

    function automatic bit fmatch(logic [TIME_W-1:0] t, logic [TIME_W-1:0] a,
                                  logic [NUM_FIELDS-1:0] e);
        bit ok;
        if (e == '0) return 1'b0;
        ok = 1'b1;
        for (int f = 0; f < NUM_FIELDS; f++)
            if (e[f])
                for (int b = 0; b < FLD_W[f]; b++)
                    if (t[FLD_LO[f]+b] !== a[FLD_LO[f]+b]) ok = 1'b0;
        return ok;
    endfunction

    function automatic bit exp_irq_n();
        bit act;
        act = 1'b0;
        for (int a = 0; a < N; a++)
            if (ie[a] && m_st[a] != 0) act = 1'b1;
        return !act;
    endfunction

    task automatic check(bit ok, string req, int act, int expv, string what);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic model_step();
        for (int a = 0; a < N; a++) begin
            bit m;
            m = tick && fmatch(now, at[a*TIME_W +: TIME_W], fe[a*NUM_FIELDS +: NUM_FIELDS]);
            if (m) begin
                m_flag[a] = 1'b1;
                m_st[a]   = pm[a] ? 2 : 1;
                m_cnt[a]  = P - 1;
            end else begin
                if (clr[a]) m_flag[a] = 1'b0;
                if (m_st[a] == 1 && clr[a]) m_st[a] = 0;
                else if (m_st[a] == 2) begin
                    if (m_cnt[a] == 0) m_st[a] = 0;
                    else m_cnt[a]--;
                end
            end
        end
    endtask

    // One clock: model advances at the rising edge, outputs compared at the falling edge
    task automatic cycle();
        @(posedge clk);
        if (!rst_n) begin
            for (int a = 0; a < N; a++) begin
                m_st[a] = 0; m_cnt[a] = 0; m_flag[a] = 1'b0;
            end
        end else begin
            model_step();
        end
        @(negedge clk);
        for (int a = 0; a < N; a++)
            check(flag[a] === m_flag[a], tag, int'(flag[a]), int'(m_flag[a]), $sformatf("flag%0d", a));
        check(irq_n === exp_irq_n(), tag, int'(irq_n), int'(exp_irq_n()), "irq_n");
    endtask

    task automatic set_alarm(int a, logic [TIME_W-1:0] t, logic [NUM_FIELDS-1:0] e,
                             bit mode, bit en);
        at[a*TIME_W +: TIME_W]         = t;
        fe[a*NUM_FIELDS +: NUM_FIELDS] = e;
        pm[a] = mode;
        ie[a] = en;
    endtask

    task automatic tick_at(logic [TIME_W-1:0] t);
        now = t; tick = 1'b1; cycle(); tick = 1'b0;
    endtask

    task automatic clear_all();
        clr = '1; cycle(); clr = '0;
        for (int k = 0; k < P + 1; k++) cycle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061023));
        rst_n = 1'b0; tick = 1'b0; now = '0; at = '0; fe = '0;
        pm = '0; ie = '0; clr = '0;

        // R10: reset state
        tag = "R10";
        for (int k = 0; k < 3; k++) cycle();
        check(flag == '0 && irq_n == 1'b1, "R10", int'(flag), 0, "reset outputs");
        @(negedge clk); rst_n = 1'b1;
        cycle(); cycle();
        check(flag == '0 && irq_n == 1'b1, "R10", int'(flag), 0, "after release");

        // R1: seconds-only match, flag set after the tick edge
        tag = "R1";
        set_alarm(0, mk('h30, 'h15, 'h08, 'h21, 'h03, 2), 6'b000001, 1'b0, 1'b0);
        tick_at(mk('h30, 'h59, 'h23, 'h01, 'h12, 5));
        check(flag[0] === 1'b1, "R1", int'(flag[0]), 1, "seconds match");
        clear_all();

        // R2: all but weekday enabled, weekday differs, still fires
        tag = "R2";
        set_alarm(0, mk('h05, 'h23, 'h05, 'h21, 'h03, 2), 6'b011111, 1'b0, 1'b0);
        tick_at(mk('h05, 'h23, 'h05, 'h21, 'h03, 6));
        check(flag[0] === 1'b1, "R2", int'(flag[0]), 1, "masked weekday ignored");
        clear_all();
        tick_at(mk('h05, 'h24, 'h05, 'h21, 'h03, 2));
        check(flag[0] === 1'b0, "R2", int'(flag[0]), 0, "enabled minute differs");

        // R3: empty mask never fires
        tag = "R3";
        set_alarm(0, mk('h05, 'h23, 'h05, 'h21, 'h03, 2), 6'b000000, 1'b0, 1'b1);
        tick_at(mk('h05, 'h23, 'h05, 'h21, 'h03, 2));
        cycle();
        check(flag[0] === 1'b0 && irq_n === 1'b1, "R3", int'(flag[0]), 0, "empty mask");

        // R4: matching time without tick
        tag = "R4";
        set_alarm(0, mk('h00, 0, 0, 0, 0, 3), 6'b100000, 1'b0, 1'b1);
        now = mk('h11, 'h22, 'h03, 'h04, 'h05, 3);
        for (int k = 0; k < 4; k++) cycle();
        check(flag[0] === 1'b0 && irq_n === 1'b1, "R4", int'(flag[0]), 0, "no tick no fire");

        // R6: level interrupt held until clear
        tag = "R6";
        tick_at(now);
        for (int k = 0; k < 12; k++) cycle();
        check(irq_n === 1'b0, "R6", int'(irq_n), 0, "level held");

        // R5: clear drops flag; match beats clear
        tag = "R5";
        clr[0] = 1'b1; cycle(); clr[0] = 1'b0;
        check(flag[0] === 1'b0 && irq_n === 1'b1, "R5", int'(flag[0]), 0, "clear");
        clr[0] = 1'b1; tick = 1'b1; cycle(); clr[0] = 1'b0; tick = 1'b0;
        check(flag[0] === 1'b1, "R5", int'(flag[0]), 1, "match wins over clear");
        clear_all();

        // R7: pulse width and restart
        tag = "R7";
        set_alarm(0, mk('h00, 0, 0, 0, 0, 3), 6'b100000, 1'b1, 1'b1);
        begin
            int lows;
            lows = 0;
            tick_at(now);
            if (irq_n === 1'b0) lows++;
            for (int k = 0; k < 2 * P; k++) begin
                cycle();
                if (irq_n === 1'b0) lows++;
            end
            check(lows == P, "R7", lows, P, "pulse low cycles");
            check(flag[0] === 1'b1, "R7", int'(flag[0]), 1, "pulse sets flag");
            lows = 0;
            tick_at(now);
            for (int k = 0; k < P - 3; k++) cycle();
            clr[0] = 1'b1;
            tick_at(now);
            clr[0] = 1'b0;
            if (irq_n === 1'b0) lows++;
            for (int k = 0; k < 2 * P; k++) begin
                cycle();
                if (irq_n === 1'b0) lows++;
            end
            check(lows == P, "R7", lows, P, "restart gives full pulse");
        end
        clear_all();

        // R8: enable gates the line but not the flag
        tag = "R8";
        set_alarm(0, mk('h00, 0, 0, 0, 0, 3), 6'b100000, 1'b0, 1'b0);
        tick_at(now);
        check(flag[0] === 1'b1 && irq_n === 1'b1, "R8", int'(irq_n), 1, "disabled interrupt");
        ie[0] = 1'b1; cycle();
        check(irq_n === 1'b0, "R8", int'(irq_n), 0, "enable exposes latched request");
        clear_all();

        // R9: alarm 1 fires alone
        tag = "R9";
        set_alarm(0, mk('h00, 'h00, 0, 0, 0, 0), 6'b000011, 1'b0, 1'b1);
        set_alarm(1, mk('h45, 'h10, 0, 0, 0, 0), 6'b000011, 1'b0, 1'b1);
        tick_at(mk('h45, 'h10, 'h01, 'h01, 'h01, 1));
        check(flag === 2'b10, "R9", int'(flag), 2, "independent alarms");
        clear_all();

        // Random phase (R9 tag: both alarms active together)
        tag = "R9";
        for (int it = 0; it < 4000; it++) begin
            if (it % 200 == 0) begin
                for (int a = 0; a < N; a++)
                    set_alarm(a, TIME_W'({$urandom, $urandom}),
                              NUM_FIELDS'($urandom % 64), 1'($urandom), 1'($urandom));
            end
            begin
                logic [TIME_W-1:0] src, t;
                src = at[($urandom % N)*TIME_W +: TIME_W];
                t   = TIME_W'({$urandom, $urandom});
                for (int f = 0; f < NUM_FIELDS; f++)
                    if ($urandom % 10 < 8)
                        for (int b = 0; b < FLD_W[f]; b++) t[FLD_LO[f]+b] = src[FLD_LO[f]+b];
                now = t;
            end
            tick = ($urandom % 4 == 0);
            clr  = N'(($urandom % 8 == 0) ? $urandom : 0);
            if ($urandom % 50 == 0) ie = N'($urandom);
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule